// File: doc/BRIEF.md
# USB Host Interrupt Status Unit

This block holds the 8-bit interrupt status word of a small USB host/peripheral controller. It samples the D+ and D- line levels through a synchronizer and classifies the bus as SE0, IDLE (D+ high, D- low) or another state. It filters out short changes and records device attach and detach in a sticky bit. It also latches single-cycle event pulses from two transfer-done sources, an SOF timer tick and a resume detector. Bit 7 is the live D+ level. After an attach, software reads it to tell a full-speed device (1) from a low-speed one (0).

Bit 6 has two meanings, selected by a mode input. With the mode input high, it is a sticky resume interrupt. With the mode input low, it is a live flag that reads 1 while no device is attached. Software reads the word at one configurable address and clears sticky bits by writing ones to them. An interrupt request output combines the sticky bits with an enable mask.

Top module: `usb_irq_stat`

## Requirements
- R1: While reset is asserted and after it is released, every sticky bit is 0, the filtered bus state is SE0 (no device), the status word reads 0x40 in mode 0 with D+ low, and irqOut is 0.
- R2: Bit 7 equals the D+ input as sampled two rising edges earlier, through a two-stage synchronizer. It is never latched.
- R3: With resumeMode at 0, bit 6 reads 1 while the filtered bus state is SE0 and 0 once an attach has been accepted.
- R4: With resumeMode at 1, bit 6 is a sticky bit that a resumeEvt pulse sets. A resumeEvt pulse while resumeMode is 0 does not set it.
- R5: Bit 5 sets when the synchronized bus state changes between SE0 and IDLE and the new state holds for STABLE_CYCLES+1 consecutive samples. The bit is visible after the edge that takes the last of those samples. Shorter excursions and the other two bus states (D- high, or both lines high) leave both bit 5 and the filtered state unchanged.
- R6: A one-cycle pulse sets a sticky bit at the next rising edge: doneA sets bit 0, doneB sets bit 1 and sofTick sets bit 4.
- R7: Bits 3 and 2 always read 0. regRdData is 0 when regAddr is not STATUS_ADDR.
- R8: A write to STATUS_ADDR clears each sticky bit (0, 1, 4, 5, 6) whose data bit is 1 at the next edge. Bits written with 0 keep their value.
- R9: When an event and a write-1 clear reach the same bit in the same cycle, the bit stays set.
- R10: irqOut is the OR of (sticky bit AND irqEnMask bit) over bits 0, 1, 4 and 5, plus bit 6 when resumeMode is 1. Bits 7, 3 and 2 never raise it.
- R11: A write to any address other than STATUS_ADDR changes no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dpIn | input | 1 | D+ line level (asynchronous) |
| dmIn | input | 1 | D- line level (asynchronous) |
| resumeMode | input | 1 | 1: bit 6 is sticky resume interrupt; 0: bit 6 is device-absent flag |
| resumeEvt | input | 1 | Resume detected pulse |
| sofTick | input | 1 | SOF timer expiry pulse |
| doneA | input | 1 | Transfer channel A done pulse |
| doneB | input | 1 | Transfer channel B done pulse |
| regAddr | input | ADDR_W | Register address |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | 8 | Write data (ones clear) |
| regRdData | output | 8 | Read data, combinational |
| irqEnMask | input | 8 | Interrupt enable mask |
| irqOut | output | 1 | Interrupt request |

## Verification
Each result has its own latency. Event pulses and write-1 clears show at the first rising edge after they are driven. Bit 7 follows D+ two edges after sampling. An attach or detach appears STABLE_CYCLES+2 edges after the first edge that samples the new level. The read data and irqOut follow the sticky bits with no further delay. The bench drives inputs on falling edges and advances a behavioural model at every rising edge from a queue of past line samples and a queue of past bus states. It compares each status field and irqOut 2 ns after the edge, so every latency is checked on the exact cycle. Directed reads at falling edges confirm the named corner cases.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;

  localparam int STAT_W = 8;

  // Bit positions of the status word
  localparam int BIT_DONE_A = 0;
  localparam int BIT_DONE_B = 1;
  localparam int BIT_SOF    = 4;
  localparam int BIT_ATTACH = 5;
  localparam int BIT_RESUME = 6;
  localparam int BIT_DPLUS  = 7;

  // Bits that hold a sticky flag
  localparam logic [STAT_W-1:0] LATCHED_MASK = 8'b0111_0011;

  typedef enum logic [1:0] {
    BUS_SE0  = 2'd0,
    BUS_IDLE = 2'd1,
    BUS_K    = 2'd2,
    BUS_SE1  = 2'd3
  } busState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic [STAT_W-1:0] setMask;
    logic [STAT_W-1:0] clrMask;
  } statStrobe_t;

  function automatic busState_e classifyBus(input logic dp, input logic dm);
    busState_e s;
    case ({dp, dm})
      2'b00:   s = BUS_SE0;
      2'b10:   s = BUS_IDLE;
      2'b01:   s = BUS_K;
      default: s = BUS_SE1;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/irq_stat_ctrl.sv
module irq_stat_ctrl
  import irq_stat_pkg::*;
#(
  parameter int                ADDR_W        = 4,
  parameter logic [ADDR_W-1:0] STATUS_ADDR   = 4'h3,
  parameter int                STABLE_CYCLES = 16,
  parameter int                SYNC_STAGES   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dpIn,
  input  logic              dmIn,
  input  logic              resumeMode,
  input  logic              resumeEvt,
  input  logic              sofTick,
  input  logic              doneA,
  input  logic              doneB,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [STAT_W-1:0] regWrData,
  output statStrobe_t       strb,
  output logic              dpLevel,
  output logic              devAbsent
);

  localparam int CNT_W = (STABLE_CYCLES > 1) ? $clog2(STABLE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STABLE_CYCLES - 1);

  // Line synchronizers
  logic [SYNC_STAGES-1:0] dpSync;
  logic [SYNC_STAGES-1:0] dmSync;

  generate
    for (genvar st = 0; st < SYNC_STAGES; st++) begin : g_sync
      if (st == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            dpSync[0] <= 1'b0;
            dmSync[0] <= 1'b0;
          end else begin
            dpSync[0] <= dpIn;
            dmSync[0] <= dmIn;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            dpSync[st] <= 1'b0;
            dmSync[st] <= 1'b0;
          end else begin
            dpSync[st] <= dpSync[st-1];
            dmSync[st] <= dmSync[st-1];
          end
        end
      end
    end
  endgenerate

  // Bus state filter
  busState_e        rawState;
  busState_e        candState;
  busState_e        fltState;
  logic [CNT_W-1:0] holdCnt;
  logic             candValid;
  logic             commitChange;

  assign rawState     = classifyBus(dpSync[SYNC_STAGES-1], dmSync[SYNC_STAGES-1]);
  assign candValid    = (candState == BUS_SE0) || (candState == BUS_IDLE);
  assign commitChange = (rawState == candState) && (holdCnt == CNT_LAST) &&
                        candValid && (candState != fltState);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      candState <= BUS_SE0;
      holdCnt   <= '0;
    end else if (rawState != candState) begin
      candState <= rawState;
      holdCnt   <= '0;
    end else if (holdCnt != CNT_LAST) begin
      holdCnt   <= holdCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fltState <= BUS_SE0;
    end else if (commitChange) begin
      fltState <= candState;
    end
  end

  // Strobe generation
  logic regHit;
  assign regHit = regWrEn && (regAddr == STATUS_ADDR);

  always_comb begin
    strb.setMask             = '0;
    strb.setMask[BIT_DONE_A] = doneA;
    strb.setMask[BIT_DONE_B] = doneB;
    strb.setMask[BIT_SOF]    = sofTick;
    strb.setMask[BIT_ATTACH] = commitChange;
    strb.setMask[BIT_RESUME] = resumeMode & resumeEvt;
    strb.clrMask             = regHit ? (regWrData & LATCHED_MASK) : '0;
  end

  assign dpLevel   = dpSync[SYNC_STAGES-1];
  assign devAbsent = (fltState == BUS_SE0);

endmodule

// File: rtl/irq_stat_dp.sv
module irq_stat_dp
  import irq_stat_pkg::*;
#(
  parameter int                ADDR_W      = 4,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 4'h3
) (
  input  logic              clk,
  input  logic              rstN,
  input  statStrobe_t       strb,
  input  logic              dpLevel,
  input  logic              devAbsent,
  input  logic              resumeMode,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [STAT_W-1:0] irqEnMask,
  output logic [STAT_W-1:0] statusWord,
  output logic [STAT_W-1:0] regRdData,
  output logic              irqOut
);

  logic [STAT_W-1:0] latQ;

  generate
    for (genvar b = 0; b < STAT_W; b++) begin : g_bit
      if (LATCHED_MASK[b]) begin : g_sticky
        logic q;
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) q <= 1'b0;
          else       q <= strb.setMask[b] | (q & ~strb.clrMask[b]);
        end
        assign latQ[b] = q;
      end else begin : g_plain
        assign latQ[b] = 1'b0;
      end
    end
  endgenerate

  logic unusedStrb;
  assign unusedStrb = ^{strb.setMask & ~LATCHED_MASK, strb.clrMask & ~LATCHED_MASK};

  always_comb begin
    statusWord             = latQ;
    statusWord[BIT_DPLUS]  = dpLevel;
    statusWord[BIT_RESUME] = resumeMode ? latQ[BIT_RESUME] : devAbsent;
  end

  logic [STAT_W-1:0] irqGate;
  always_comb begin
    irqGate             = LATCHED_MASK;
    irqGate[BIT_RESUME] = resumeMode;
  end

  assign irqOut    = |(latQ & irqGate & irqEnMask);
  assign regRdData = (regAddr == STATUS_ADDR) ? statusWord : '0;

endmodule

// File: rtl/usb_irq_stat.sv
module usb_irq_stat
  import irq_stat_pkg::*;
#(
  parameter int                ADDR_W        = 4,
  parameter logic [ADDR_W-1:0] STATUS_ADDR   = 4'h3,
  parameter int                STABLE_CYCLES = 16,
  parameter int                SYNC_STAGES   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dpIn,
  input  logic              dmIn,
  input  logic              resumeMode,
  input  logic              resumeEvt,
  input  logic              sofTick,
  input  logic              doneA,
  input  logic              doneB,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  input  logic [7:0]        irqEnMask,
  output logic              irqOut
);

  statStrobe_t       strb;
  logic              dpLevel;
  logic              devAbsent;
  logic [STAT_W-1:0] statusWord;

  irq_stat_ctrl #(
    .ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR),
    .STABLE_CYCLES(STABLE_CYCLES), .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .dpIn(dpIn), .dmIn(dmIn),
    .resumeMode(resumeMode), .resumeEvt(resumeEvt), .sofTick(sofTick),
    .doneA(doneA), .doneB(doneB), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .strb(strb), .dpLevel(dpLevel), .devAbsent(devAbsent)
  );

  irq_stat_dp #(
    .ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .dpLevel(dpLevel),
    .devAbsent(devAbsent), .resumeMode(resumeMode), .regAddr(regAddr),
    .irqEnMask(irqEnMask), .statusWord(statusWord), .regRdData(regRdData),
    .irqOut(irqOut)
  );

endmodule

// File: rtl/irq_stat_checker.sv
module irq_stat_checker #(
  parameter int                ADDR_W      = 4,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 4'h3
) (
  input logic              clk,
  input logic              rstN,
  input logic              resumeMode,
  input logic              resumeEvt,
  input logic              sofTick,
  input logic              doneA,
  input logic              doneB,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWrEn,
  input logic [7:0]        regWrData,
  input logic [7:0]        irqEnMask,
  input logic              irqOut,
  input logic [7:0]        statusWord,
  input logic              attachStrobe
);

  logic clrHit;
  assign clrHit = regWrEn && (regAddr == STATUS_ADDR);

  p_sof_sets_r6: assert property (@(posedge clk) disable iff (!rstN)
    sofTick |=> statusWord[4]);

  p_donea_sets_r6: assert property (@(posedge clk) disable iff (!rstN)
    doneA |=> statusWord[0]);

  p_clear_doneb_r8: assert property (@(posedge clk) disable iff (!rstN)
    (clrHit && regWrData[1] && !doneB) |=> !statusWord[1]);

  p_hold_donea_r8: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord[0] && !(clrHit && regWrData[0])) |=> statusWord[0]);

  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
    (clrHit && regWrData[4] && sofTick) |=> statusWord[4]);

  p_attach_source_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusWord[5]) |-> $past(attachStrobe));

  p_resume_sets_r4: assert property (@(posedge clk) disable iff (!rstN)
    (resumeMode && resumeEvt) |=> (!resumeMode || statusWord[6]));

  p_irq_masked_r10: assert property (@(posedge clk) disable iff (!rstN)
    (irqEnMask == 8'h00) |-> !irqOut);

  p_other_addr_r11: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && (regAddr != STATUS_ADDR) && statusWord[1]) |=> statusWord[1]);

endmodule

bind usb_irq_stat irq_stat_checker #(
  .ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR)
) u_chk (
  .clk(clk), .rstN(rstN), .resumeMode(resumeMode), .resumeEvt(resumeEvt),
  .sofTick(sofTick), .doneA(doneA), .doneB(doneB), .regAddr(regAddr),
  .regWrEn(regWrEn), .regWrData(regWrData), .irqEnMask(irqEnMask),
  .irqOut(irqOut), .statusWord(statusWord), .attachStrobe(strb.setMask[5])
);

// File: tb/tb_usb_irq_stat.sv
module tb_usb_irq_stat;

  localparam int         STABLE = 16;
  localparam logic [3:0] SA     = 4'h3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rstN, dpIn, dmIn, resumeMode, resumeEvt, sofTick, doneA, doneB;
  logic [3:0] regAddr;
  logic       regWrEn;
  logic [7:0] regWrData, regRdData, irqEnMask;
  logic       irqOut;

  int vectors = 0;
  int fails   = 0;
  bit finished = 0;

  usb_irq_stat #(.ADDR_W(4), .STATUS_ADDR(SA), .STABLE_CYCLES(STABLE), .SYNC_STAGES(2)) dut (
    .clk(clk), .rstN(rstN), .dpIn(dpIn), .dmIn(dmIn), .resumeMode(resumeMode),
    .resumeEvt(resumeEvt), .sofTick(sofTick), .doneA(doneA), .doneB(doneB),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .irqEnMask(irqEnMask), .irqOut(irqOut)
  );

  task automatic cmp(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  logic [1:0] inQ[$];
  int         rawQ[$];
  int         mFlt;
  logic [7:0] mLat;

  function automatic int busCls(input logic [1:0] s);
    if (s == 2'b00) return 0;
    if (s == 2'b10) return 1;
    return 2;
  endfunction

  always @(posedge clk) begin
    logic [1:0] preS2;
    logic       postDp;
    logic [7:0] setM, clrM, expRd, gate;
    bit         same;
    if (!rstN) begin
      inQ.delete();
      rawQ.delete();
      mFlt = 0;
      mLat = 8'h00;
      postDp = 1'b0;
    end else begin
      preS2 = (inQ.size() >= 2) ? inQ[inQ.size()-2] : 2'b00;
      inQ.push_back({dpIn, dmIn});
      if (inQ.size() > 3) void'(inQ.pop_front());
      postDp = (inQ.size() >= 2) ? inQ[inQ.size()-2][1] : 1'b0;
      rawQ.push_back(busCls(preS2));
      if (rawQ.size() > STABLE + 1) void'(rawQ.pop_front());
      setM = {1'b0, resumeMode & resumeEvt, 1'b0, sofTick, 2'b00, doneB, doneA};
      if (rawQ.size() == STABLE + 1) begin
        same = 1;
        foreach (rawQ[i]) if (rawQ[i] != rawQ[0]) same = 0;
        if (same && rawQ[0] != 2 && rawQ[0] != mFlt) begin
          mFlt = rawQ[0];
          setM[5] = 1'b1;
        end
      end
      clrM = (regWrEn && regAddr == SA) ? (regWrData & 8'h73) : 8'h00;
      mLat = setM | (mLat & ~clrM);
    end
    #2;
    if (!finished) begin
      expRd = {postDp, resumeMode ? mLat[6] : (mFlt == 0), mLat[5], mLat[4], 2'b00, mLat[1], mLat[0]};
      if (regAddr == SA) begin
        cmp("R2 D+ level bit7", regRdData & 8'h80, expRd & 8'h80);
        cmp(resumeMode ? "R4 resume bit6" : "R3 absent bit6", regRdData & 8'h40, expRd & 8'h40);
        cmp("R5 attach/detach bit5", regRdData & 8'h20, expRd & 8'h20);
        cmp("R6 event bits 4,1,0", regRdData & 8'h13, expRd & 8'h13);
        cmp("R7 reserved bits", regRdData & 8'h0C, 8'h00);
      end else begin
        cmp("R7 off-address read", regRdData, 8'h00);
      end
      gate = mLat & irqEnMask & {1'b0, resumeMode, 6'b110011};
      cmp("R10 irq", {7'b0, irqOut}, {7'b0, |gate});
    end
  end

  // Stimulus helpers
  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1'b1;
    @(negedge clk); sig = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); regAddr = a; regWrEn = 1'b1; regWrData = d;
    @(negedge clk); regWrEn = 1'b0; regWrData = 8'h00; regAddr = SA;
  endtask

  task automatic chk(input string tag, input logic [7:0] expRd, input logic expIrq);
    @(negedge clk); #1;
    cmp(tag, regRdData, expRd);
    cmp({tag, " irq"}, {7'b0, irqOut}, {7'b0, expIrq});
  endtask

  initial begin
    rstN = 1'b0; dpIn = 1'b0; dmIn = 1'b0; resumeMode = 1'b0; resumeEvt = 1'b0;
    sofTick = 1'b0; doneA = 1'b0; doneB = 1'b0; regAddr = SA; regWrEn = 1'b0;
    regWrData = 8'h00; irqEnMask = 8'hFF;
    cyc(4);
    chk("R1 in reset", 8'h40, 1'b0);
    @(negedge clk); rstN = 1'b1;
    chk("R1 after reset", 8'h40, 1'b0);

    pulse(doneA); pulse(doneB); pulse(sofTick);
    chk("R6 events latched", 8'h53, 1'b1);

    wr(SA, 8'h01);
    chk("R8 clear bit0 only", 8'h52, 1'b1);

    @(negedge clk); sofTick = 1'b1; regWrEn = 1'b1; regWrData = 8'h10;
    @(negedge clk); sofTick = 1'b0; regWrEn = 1'b0; regWrData = 8'h00;
    chk("R9 set wins over clear", 8'h52, 1'b1);

    wr(4'h5, 8'hFF);
    chk("R11 other address write ignored", 8'h52, 1'b1);
    @(negedge clk); regAddr = 4'h5;
    chk("R7 off-address read zero", 8'h00, 1'b1);
    @(negedge clk); regAddr = SA;

    @(negedge clk); irqEnMask = 8'h00;
    chk("R10 mask all", 8'h52, 1'b0);
    @(negedge clk); irqEnMask = 8'h01;
    chk("R10 mask cleared bit", 8'h52, 1'b0);
    @(negedge clk); irqEnMask = 8'h02;
    chk("R10 mask doneB", 8'h52, 1'b1);
    @(negedge clk); irqEnMask = 8'h8C;
    chk("R10 non-sticky bits never raise irq", 8'h52, 1'b0);
    @(negedge clk); irqEnMask = 8'hFF;

    wr(SA, 8'hFF);
    chk("R8 clear all", 8'h40, 1'b0);

    @(negedge clk); dpIn = 1'b1;
    cyc(4);
    chk("R2 D+ visible", 8'hC0, 1'b0);
    cyc(3); dpIn = 1'b0;
    cyc(30);
    chk("R5 glitch ignored", 8'h40, 1'b0);

    @(negedge clk); dpIn = 1'b1;
    cyc(30);
    chk("R5 attach full speed", 8'hA0, 1'b1);
    wr(SA, 8'h20);
    chk("R3 present after attach", 8'h80, 1'b0);

    @(negedge clk); dpIn = 1'b0;
    cyc(30);
    chk("R5 detach", 8'h60, 1'b1);
    wr(SA, 8'h20);
    chk("R8 clear attach", 8'h40, 1'b0);

    pulse(resumeEvt);
    @(negedge clk); resumeMode = 1'b1;
    chk("R4 resume ignored in mode 0", 8'h00, 1'b0);
    pulse(resumeEvt);
    chk("R4 resume latched", 8'h40, 1'b1);
    @(negedge clk); irqEnMask = 8'h40; resumeMode = 1'b0;
    chk("R10 bit6 not irq in mode 0", 8'h40, 1'b0);
    @(negedge clk); resumeMode = 1'b1;
    chk("R10 bit6 irq in mode 1", 8'h40, 1'b1);
    wr(SA, 8'h40);
    chk("R8 clear resume", 8'h00, 1'b0);
    @(negedge clk); irqEnMask = 8'hFF;

    @(negedge clk); dpIn = 1'b1; dmIn = 1'b1;
    cyc(30);
    chk("R5 SE1 held no change", 8'h80, 1'b0);
    @(negedge clk); dpIn = 1'b0; dmIn = 1'b1;
    cyc(30);
    chk("R5 K held no change", 8'h00, 1'b0);
    @(negedge clk); dmIn = 1'b0;
    cyc(10);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog expired (all requirements) actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule